// File: doc/BRIEF.md
# Mailbox Pointer Register Bank

This block takes mailbox pointer writes from up to four groups of processors, all arriving at one control-register address on a system bus. A 2-bit bank field on each write carries the two low bits of the writer's virtual ID, and that field alone picks one of four register pairs. Each pair therefore lets its group keep two mailboxes outstanding. The bank holds eight pointer slots in total. A write that finds room in its pair gets a one-cycle acknowledge in the same cycle as its strobe. A write that finds no room, or that carries a pointer not aligned to 64 bytes, gets no acknowledge and leaves no trace. Software treats a missing acknowledge as busy and retries later.

Accepted pointers go downstream on a ready/valid dispatch port. They leave in strict order of acceptance across all four pairs, as if the eight slots were one queue. A dispatched slot stays occupied until a completion pulse tagged with its slot index reports that the mailbox is done. Only then may its pair accept another write. A completion and a write to the same pair in the same cycle are resolved with the completion first.

Each slot runs a three-state machine. In `SLOT_FREE` the slot is empty and may be granted. The transition *grant* moves it to `SLOT_QUEUED`, where it holds a pointer that waits in the order queue. The transition *dispatch*, a pop of the queue head while ready is high, moves it to `SLOT_INFLIGHT`. The transition *complete*, a matching completion pulse, moves it back to `SLOT_FREE`. When a grant arrives in the same cycle as complete, the transition *recycle* moves it straight to `SLOT_QUEUED`. A completion that arrives in any state other than `SLOT_INFLIGHT` is ignored.

Top module: `mbox_ptr_bank`

## Requirements
- R1: The slot index is 2*bank + k, where bank is `csr_bank` of the write and k (0 or 1) is the lowest free slot of that pair. The address never influences pair choice. The dispatch port reports that slot on `dsp_slot` and the pair on `dsp_pair`.
- R2: Each pair holds at most two occupied slots. A write to a pair whose two slots are both queued or in flight is refused.
- R3: A refused write leaves every slot and the order queue unchanged.
- R4: A write whose `csr_addr` bits [5:0] are not all zero is refused, even when its pair has room.
- R5: An accepted write raises `csr_ack` combinationally in the same cycle as `csr_wr`. `csr_ack` is never high without `csr_wr`.
- R6: Entries leave on the dispatch port in the exact order their writes were accepted, across all pairs.
- R7: `dsp_valid` rises in the cycle after an acceptance and stays high while entries wait. While `dsp_ready` is low, the head entry (`dsp_slot`, `dsp_ptr`, `dsp_pair`) holds still. A cycle with `dsp_valid` and `dsp_ready` both high pops the head.
- R8: A dispatched slot stays occupied until `done_valid` arrives with `done_slot` equal to its index. A completion for a slot that has not been dispatched is ignored.
- R9: When a completion frees a slot of a pair in the same cycle as a write to that pair, the write is accepted into the freed slot.
- R10: A synchronous active-high `rst` empties all slots and the order queue. `dsp_valid` is low in the cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Write strobe for the pointer register |
| csr_bank | input | 2 | Bank field: low two bits of the writer's virtual ID |
| csr_addr | input | 40 | Mailbox pointer (64-byte aligned) |
| csr_ack | output | 1 | Command acknowledge, high only for an accepted write |
| dsp_valid | output | 1 | A pending pointer is presented |
| dsp_ready | input | 1 | Downstream takes the presented pointer |
| dsp_ptr | output | 40 | Pointer of the head entry |
| dsp_pair | output | 2 | Pair of the head entry |
| dsp_slot | output | 3 | Slot index of the head entry |
| done_valid | input | 1 | Completion pulse for one slot |
| done_slot | input | 3 | Slot index the completion refers to |

## Verification
The assertions check several local rules on every cycle. An acknowledge always rides on a strobe with an aligned address. A slot is granted only while it is free or being freed, and dispatched only while queued. An in-flight slot stays in flight until its completion. The order queue never overflows or underflows, and a stalled head holds still. Global dispatch order across pairs, lowest-slot choice inside a pair, ignored early completions and the same-cycle completion-then-write case can only be shown by the bench's scenarios, which compare every dispatched entry with a model kept from the requirements.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef enum logic [1:0] {
        SLOT_FREE     = 2'd0,
        SLOT_QUEUED   = 2'd1,
        SLOT_INFLIGHT = 2'd2
    } slot_state_e;

endpackage

// File: rtl/mbox_slot.sv
module mbox_slot
    import mbox_pkg::*;
#(
    parameter int PTR_W = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             grant_i,
    input  logic [PTR_W-1:0] ptr_i,
    input  logic             send_i,
    input  logic             done_i,
    output slot_state_e      state_o,
    output logic [PTR_W-1:0] ptr_o
);

    slot_state_e state_q, state_d;
    logic [PTR_W-1:0] ptr_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SLOT_FREE;
        else     state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE: begin
                if (grant_i) state_d = SLOT_QUEUED;            // grant
            end
            SLOT_QUEUED: begin
                if (send_i) state_d = SLOT_INFLIGHT;           // dispatch
            end
            SLOT_INFLIGHT: begin
                if (done_i && grant_i) state_d = SLOT_QUEUED;  // recycle
                else if (done_i)       state_d = SLOT_FREE;    // complete
            end
            default: state_d = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)          ptr_q <= '0;
        else if (grant_i) ptr_q <= ptr_i;
    end

    assign state_o = state_q;
    assign ptr_o   = ptr_q;

    // R2: a slot is granted only when free or being freed this cycle
    p_grant_free_r2: assert property (@(posedge clk) disable iff (rst)
        grant_i |-> (state_q == SLOT_FREE) || (state_q == SLOT_INFLIGHT && done_i));

    // R7: only a queued slot can be popped
    p_send_queued_r7: assert property (@(posedge clk) disable iff (rst)
        send_i |-> state_q == SLOT_QUEUED);

    // R8: an in-flight slot stays in flight until its completion
    p_hold_inflight_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == SLOT_INFLIGHT && !done_i) |=> state_q == SLOT_INFLIGHT);

endmodule

// File: rtl/mbox_order_fifo.sv
module mbox_order_fifo #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic [IDX_W-1:0] push_idx_i,
    input  logic             pop_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] head_o
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [IDX_W-1:0] mem_q [DEPTH];
    logic [PW-1:0]    wr_q, rd_q;
    logic [CW-1:0]    cnt_q;
    logic             full;

    assign full    = (cnt_q == CW'(DEPTH));
    assign valid_o = (cnt_q != '0);
    assign head_o  = mem_q[rd_q];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_i) begin
                mem_q[wr_q] <= push_idx_i;
                wr_q        <= bump(wr_q);
            end
            if (pop_i) rd_q <= bump(rd_q);
            unique case ({push_i, pop_i})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R6: the order queue never overflows
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        push_i |-> !full);

    // R7: no pop from an empty queue
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
        pop_i |-> valid_o);

endmodule

// File: rtl/mbox_alloc.sv
module mbox_alloc #(
    parameter int NUM_PAIRS = 4,
    parameter int PER_PAIR  = 2,
    parameter int NSLOT     = NUM_PAIRS * PER_PAIR,
    parameter int BANK_W    = 2,
    parameter int SLOT_W    = 3
) (
    input  logic              wr_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic              aligned_i,
    input  logic [NSLOT-1:0]  free_i,
    output logic              ack_o,
    output logic [NSLOT-1:0]  grant_o,
    output logic [SLOT_W-1:0] grant_idx_o
);

    logic found;

    // lowest free slot inside the addressed pair
    always_comb begin
        found       = 1'b0;
        grant_idx_o = '0;
        for (int k = 0; k < PER_PAIR; k++) begin
            int s;
            s = int'(bank_i) * PER_PAIR + k;
            if (!found && free_i[s]) begin
                found       = 1'b1;
                grant_idx_o = SLOT_W'(s);
            end
        end
        ack_o   = wr_i && aligned_i && found;
        grant_o = '0;
        grant_o[grant_idx_o] = ack_o;
    end

endmodule

// File: rtl/mbox_ptr_bank.sv
module mbox_ptr_bank
    import mbox_pkg::*;
#(
    parameter int NUM_PAIRS  = 4,
    parameter int PER_PAIR   = 2,
    parameter int ADDR_W     = 40,
    parameter int ALIGN_BITS = 6
) (
    input  logic                                        clk,
    input  logic                                        rst,
    input  logic                                        csr_wr,
    input  logic [$clog2(NUM_PAIRS)-1:0]                csr_bank,
    input  logic [ADDR_W-1:0]                           csr_addr,
    output logic                                        csr_ack,
    output logic                                        dsp_valid,
    input  logic                                        dsp_ready,
    output logic [ADDR_W-1:0]                           dsp_ptr,
    output logic [$clog2(NUM_PAIRS)-1:0]                dsp_pair,
    output logic [$clog2(NUM_PAIRS*PER_PAIR)-1:0]       dsp_slot,
    input  logic                                        done_valid,
    input  logic [$clog2(NUM_PAIRS*PER_PAIR)-1:0]       done_slot
);

    localparam int NSLOT  = NUM_PAIRS * PER_PAIR;
    localparam int SLOT_W = $clog2(NSLOT);
    localparam int BANK_W = $clog2(NUM_PAIRS);

    slot_state_e       slot_state [NSLOT];
    logic [ADDR_W-1:0] slot_ptr   [NSLOT];
    logic [NSLOT-1:0]  done_hit, send, grant, free_eff;
    logic [SLOT_W-1:0] grant_idx, head_idx, head_pair_full;
    logic              aligned, pop;

    assign aligned = (csr_addr[ALIGN_BITS-1:0] == '0);
    assign pop     = dsp_valid && dsp_ready;

    mbox_alloc #(
        .NUM_PAIRS (NUM_PAIRS),
        .PER_PAIR  (PER_PAIR),
        .NSLOT     (NSLOT),
        .BANK_W    (BANK_W),
        .SLOT_W    (SLOT_W)
    ) u_alloc (
        .wr_i        (csr_wr),
        .bank_i      (csr_bank),
        .aligned_i   (aligned),
        .free_i      (free_eff),
        .ack_o       (csr_ack),
        .grant_o     (grant),
        .grant_idx_o (grant_idx)
    );

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        assign done_hit[i] = done_valid && (done_slot == SLOT_W'(i));
        assign send[i]     = pop && (head_idx == SLOT_W'(i));
        assign free_eff[i] = (slot_state[i] == SLOT_FREE) ||
                             (slot_state[i] == SLOT_INFLIGHT && done_hit[i]);

        mbox_slot #(.PTR_W(ADDR_W)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .grant_i (grant[i]),
            .ptr_i   (csr_addr),
            .send_i  (send[i]),
            .done_i  (done_hit[i]),
            .state_o (slot_state[i]),
            .ptr_o   (slot_ptr[i])
        );
    end

    mbox_order_fifo #(
        .DEPTH (NSLOT),
        .IDX_W (SLOT_W)
    ) u_order (
        .clk        (clk),
        .rst        (rst),
        .push_i     (csr_ack),
        .push_idx_i (grant_idx),
        .pop_i      (pop),
        .valid_o    (dsp_valid),
        .head_o     (head_idx)
    );

    assign head_pair_full = head_idx / SLOT_W'(PER_PAIR);
    assign dsp_slot = head_idx;
    assign dsp_pair = head_pair_full[BANK_W-1:0];
    assign dsp_ptr  = slot_ptr[head_idx];

    // R5: acknowledge only accompanies a strobe
    p_ack_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        csr_ack |-> csr_wr);

    // R4: acknowledge never granted to a misaligned pointer
    p_ack_aligned_r4: assert property (@(posedge clk) disable iff (rst)
        csr_ack |-> csr_addr[ALIGN_BITS-1:0] == '0);

    // R1: an acknowledged write lands as a queued slot
    p_grant_lands_r1: assert property (@(posedge clk) disable iff (rst)
        csr_ack |=> dsp_valid);

    // R7: a stalled head holds still
    p_head_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (dsp_valid && !dsp_ready) |=> dsp_valid && $stable(dsp_slot) && $stable(dsp_ptr));

    // R7: the presented head is always a queued slot
    p_head_queued_r7: assert property (@(posedge clk) disable iff (rst)
        dsp_valid |-> slot_state[head_idx] == SLOT_QUEUED);

    // R10: nothing is presented right after reset
    p_reset_empty_r10: assert property (@(posedge clk)
        rst |=> !dsp_valid);

endmodule

// File: tb/test_mbox_ptr_bank.sv
module test_mbox_ptr_bank;

    localparam int AW = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          csr_wr = 1'b0;
    logic [1:0]    csr_bank = '0;
    logic [AW-1:0] csr_addr = '0;
    logic          csr_ack;
    logic          dsp_valid;
    logic          dsp_ready = 1'b0;
    logic [AW-1:0] dsp_ptr;
    logic [1:0]    dsp_pair;
    logic [2:0]    dsp_slot;
    logic          done_valid = 1'b0;
    logic [2:0]    done_slot = '0;

    always #10 clk = ~clk;   // 50 MHz

    mbox_ptr_bank i_mbox_ptr_bank (
        .clk(clk), .rst(rst),
        .csr_wr(csr_wr), .csr_bank(csr_bank), .csr_addr(csr_addr), .csr_ack(csr_ack),
        .dsp_valid(dsp_valid), .dsp_ready(dsp_ready), .dsp_ptr(dsp_ptr),
        .dsp_pair(dsp_pair), .dsp_slot(dsp_slot),
        .done_valid(done_valid), .done_slot(done_slot)
    );

    int checks = 0;
    int fails  = 0;
    int nptr   = 0;

    // model: 0 free, 1 queued, 2 in flight
    int            occ  [8];
    logic [AW-1:0] sptr [8];
    int            q    [$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int pick(input int b);
        for (int k = 0; k < 2; k++)
            if (occ[2*b+k] == 0) return 2*b + k;
        return -1;
    endfunction

    function automatic logic [AW-1:0] next_ptr();
        nptr++;
        return AW'(nptr) << 12;
    endfunction

    // one-cycle write, optionally with a completion in the same cycle
    task automatic wr(input int b, input logic [AW-1:0] a, input bit dv, input int ds,
                      input string req);
        int  s;
        bit  exp;
        @(negedge clk);
        csr_wr = 1'b1; csr_bank = 2'(b); csr_addr = a;
        done_valid = dv; done_slot = 3'(ds);
        if (dv && occ[ds] == 2) occ[ds] = 0;
        s   = pick(b);
        exp = (a[5:0] == 6'd0) && (s >= 0);
        #1;
        chk(csr_ack == exp, req, "csr_ack", longint'(csr_ack), longint'(exp));
        @(posedge clk);
        #1;
        csr_wr = 1'b0; done_valid = 1'b0;
        if (exp) begin
            occ[s] = 1; sptr[s] = a; q.push_back(s);
        end
    endtask

    task automatic pop(input string req);
        int s;
        @(negedge clk);
        chk(dsp_valid == 1'b1, req, "dsp_valid", longint'(dsp_valid), 1);
        if (q.size() == 0) return;
        s = q[0];
        chk(dsp_slot == 3'(s), req, "dsp_slot", longint'(dsp_slot), longint'(s));
        chk(dsp_ptr == sptr[s] && dsp_pair == 2'(s / 2), req, "dsp_ptr/pair",
            longint'(dsp_ptr), longint'(sptr[s]));
        dsp_ready = 1'b1;
        @(posedge clk);
        #1;
        dsp_ready = 1'b0;
        void'(q.pop_front());
        occ[s] = 2;
    endtask

    task automatic done(input int s);
        @(negedge clk);
        done_valid = 1'b1; done_slot = 3'(s);
        @(posedge clk);
        #1;
        done_valid = 1'b0;
        if (occ[s] == 2) occ[s] = 0;
    endtask

    task automatic drain(input string req);
        while (q.size() > 0) pop(req);
        @(negedge clk);
        chk(dsp_valid == 1'b0, req, "dsp_valid after drain", longint'(dsp_valid), 0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        int order [8] = '{2, 0, 3, 1, 1, 3, 0, 2};
        logic [AW-1:0] keep;
        for (int i = 0; i < 8; i++) occ[i] = 0;

        // R10: reset state
        repeat (3) @(posedge clk);
        #1;
        chk(dsp_valid == 1'b0, "R10", "dsp_valid in reset", longint'(dsp_valid), 0);
        chk(csr_ack == 1'b0, "R5", "csr_ack idle", longint'(csr_ack), 0);
        @(negedge clk);
        rst = 1'b0;

        // R1 R5 R6: interleaved fill of all pairs
        for (int i = 0; i < 8; i++) wr(order[i], next_ptr(), 0, 0, "R5");
        // R2 R3: every pair is full now
        for (int b = 0; b < 4; b++) wr(b, next_ptr(), 0, 0, "R2");
        // R6 R1: global order
        drain("R6");

        // R8: in-flight slots still block writes
        for (int b = 0; b < 4; b++) wr(b, next_ptr(), 0, 0, "R8");
        done(5);
        wr(2, next_ptr(), 0, 0, "R8");
        wr(2, next_ptr(), 0, 0, "R8");
        drain("R1");
        for (int s = 0; s < 8; s++) done(s);

        // R4 R3: misaligned pointers refused, nothing queued
        for (int bit_i = 0; bit_i < 6; bit_i++)
            wr(1, next_ptr() | (AW'(1) << bit_i), 0, 0, "R4");
        @(negedge clk);
        chk(dsp_valid == 1'b0, "R3", "no entry from refused writes", longint'(dsp_valid), 0);
        wr(1, next_ptr(), 0, 0, "R3");
        wr(1, next_ptr(), 0, 0, "R3");

        // R7: stalled head holds
        keep = sptr[q[0]];
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk(dsp_valid && dsp_slot == 3'd2 && dsp_ptr == keep, "R7", "held head",
                longint'(dsp_ptr), longint'(keep));
        end

        // R8: completion on a queued slot is ignored
        done(3);
        drain("R7");
        wr(1, next_ptr(), 0, 0, "R8");

        // R9: completion and write to the same pair in one cycle
        wr(1, next_ptr(), 1, 3, "R9");
        pop("R9");
        wr(1, next_ptr(), 1, 2, "R9");
        drain("R9");
        for (int s = 0; s < 8; s++) done(s);

        // R10: reset mid-operation
        wr(0, next_ptr(), 0, 0, "R10");
        wr(3, next_ptr(), 0, 0, "R10");
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        chk(dsp_valid == 1'b0, "R10", "dsp_valid after reset", longint'(dsp_valid), 0);
        for (int i = 0; i < 8; i++) occ[i] = 0;
        q.delete();
        for (int i = 7; i >= 0; i--) wr(order[i], next_ptr(), 0, 0, "R10");
        drain("R10");

        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

endmodule